// File: doc/BRIEF.md
# Outstanding Line Miss Tracker

This block keeps a small table of the cache lines a non-blocking cache is still waiting on. Each miss brings a line address and a target made of a requester ID and a word offset. If no valid entry holds that line, the miss takes the lowest free entry, and one fill request for the line is queued downstream. If an entry for the line already exists, the target is added to that entry and no new request goes out. Only the misses that cannot be taken raise the stall output.

A fill response names the entry it answers. The block latches the returned line and then presents every target recorded in that entry, one per cycle, in the order the targets arrived. After the last target it releases the entry. While the targets are being presented, new responses are held off. A miss to the line being presented is stalled until the entry is free. It then counts as a fresh primary miss.

Top module: `miss_track_file`

## Requirements
- R1: After reset no entry is valid, and `fill_req_valid_o`, `replay_valid_o` and `stall_o` are low while `fill_rsp_ready_o` is high.
- R2: A miss whose line matches no valid entry is accepted without stall when an entry is free, and it occupies the lowest-numbered free entry; that entry number is the `fill_req_idx_o` later sent with the line.
- R3: Each accepted primary miss produces exactly one fill request. A presented request keeps its index and line unchanged until `fill_req_ready_i` is high, and waiting requests are presented lowest entry first.
- R4: A miss to a line with a valid entry that is not being replayed and has a free target slot is accepted without stall, stored as that entry's next target, and produces no fill request.
- R5: A secondary miss whose entry already holds `N_TGTS` targets raises `stall_o` and is not recorded.
- R6: A primary miss while all `N_ENTRIES` entries are valid raises `stall_o` and is not recorded.
- R7: A fill response accepted on a clock edge starts the replay in the next cycle. The replay shows one target per cycle, in recording order, each with the returned line data. `replay_valid_o` stays high for exactly as many cycles as there are targets.
- R8: The entry is freed on the edge that ends its last replay cycle. A miss to its line stalls during every replay cycle, including that last one, and in the following cycle it is accepted as a primary miss with a new fill request.
- R9: `fill_rsp_ready_o` is low during replay and high otherwise.
- R10: `stall_o` is low whenever `miss_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| miss_valid_i | input | 1 | A miss is presented this cycle |
| miss_line_i | input | LINE_AW | Line address of the miss |
| miss_id_i | input | ID_W | Requester ID of the target |
| miss_off_i | input | OFF_W | Word offset of the target |
| stall_o | output | 1 | Miss not accepted this cycle |
| fill_req_valid_o | output | 1 | Fill request presented |
| fill_req_ready_i | input | 1 | Downstream takes the fill request |
| fill_req_line_o | output | LINE_AW | Line to fetch |
| fill_req_idx_o | output | IW | Entry that owns the request |
| fill_rsp_valid_i | input | 1 | Fill data returned |
| fill_rsp_ready_o | output | 1 | Fill response can be taken |
| fill_rsp_idx_i | input | IW | Entry the data belongs to |
| fill_rsp_data_i | input | LINE_W | Returned line |
| replay_valid_o | output | 1 | A target is served this cycle |
| replay_id_o | output | ID_W | Requester ID being served |
| replay_off_o | output | OFF_W | Word offset being served |
| replay_data_o | output | LINE_W | Line data for the served target |

## Verification
The hardest case to reach is a miss whose line belongs to an entry that is being replayed, and in particular one that lands in the entry's last replay cycle. The bench builds a two-target entry, returns its fill data and then holds a miss to that same line across every replay cycle. It expects a stall in each of them. In the cycle after the replay it expects the miss to be accepted, to reuse the just-freed index and to issue a fresh fill request. Filling the table and the target slots first is done through a table-driven miss sequence.

// File: rtl/miss_track_pkg.sv
package miss_track_pkg;
  localparam int unsigned ID_W  = 4;
  localparam int unsigned OFF_W = 4;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [OFF_W-1:0] off;
  } tgt_t;
endpackage

// File: rtl/miss_low_pick.sv
module miss_low_pick #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign found_o = |req_i;
endmodule

// File: rtl/miss_line_match.sv
module miss_line_match #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 26
) (
  input  logic [N-1:0]         vld_i,
  input  logic [N-1:0][AW-1:0] lines_i,
  input  logic [AW-1:0]        line_i,
  output logic [N-1:0]         hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = vld_i[g] && (lines_i[g] == line_i);
  end
endmodule

// File: rtl/miss_track_file.sv
module miss_track_file
  import miss_track_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 4,
  parameter int unsigned N_TGTS    = 2,
  parameter int unsigned LINE_AW   = 26,
  parameter int unsigned LINE_W    = 64,
  localparam int unsigned IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               miss_valid_i,
  input  logic [LINE_AW-1:0] miss_line_i,
  input  logic [ID_W-1:0]    miss_id_i,
  input  logic [OFF_W-1:0]   miss_off_i,
  output logic               stall_o,
  output logic               fill_req_valid_o,
  input  logic               fill_req_ready_i,
  output logic [LINE_AW-1:0] fill_req_line_o,
  output logic [IW-1:0]      fill_req_idx_o,
  input  logic               fill_rsp_valid_i,
  output logic               fill_rsp_ready_o,
  input  logic [IW-1:0]      fill_rsp_idx_i,
  input  logic [LINE_W-1:0]  fill_rsp_data_i,
  output logic               replay_valid_o,
  output logic [ID_W-1:0]    replay_id_o,
  output logic [OFF_W-1:0]   replay_off_o,
  output logic [LINE_W-1:0]  replay_data_o
);
  localparam int unsigned CW = $clog2(N_TGTS + 1);
  localparam int unsigned SW = (N_TGTS > 1) ? $clog2(N_TGTS) : 1;

  logic [N_ENTRIES-1:0]              vld_q, pend_q;
  logic [N_ENTRIES-1:0][LINE_AW-1:0] line_q;
  tgt_t                              tgt_q [N_ENTRIES][N_TGTS];
  logic [CW-1:0]                     cnt_q [N_ENTRIES];

  logic              req_busy_q;
  logic [IW-1:0]     req_idx_q;
  logic              rp_act_q;
  logic [IW-1:0]     rp_idx_q;
  logic [SW-1:0]     rp_slot_q;
  logic [LINE_W-1:0] rp_data_q;

  logic [N_ENTRIES-1:0] hit;
  logic                 hit_any, free_found, pend_found;
  logic [IW-1:0]        hit_idx, free_idx, pend_idx;
  logic                 hit_busy, hit_full, acc_new, acc_sec, rp_last, rsp_fire;

  miss_line_match #(.N(N_ENTRIES), .AW(LINE_AW)) i_match (
    .vld_i(vld_q), .lines_i(line_q), .line_i(miss_line_i), .hit_o(hit)
  );
  miss_low_pick #(.N(N_ENTRIES)) i_pick_hit (
    .req_i(hit), .found_o(hit_any), .idx_o(hit_idx)
  );
  miss_low_pick #(.N(N_ENTRIES)) i_pick_free (
    .req_i(~vld_q), .found_o(free_found), .idx_o(free_idx)
  );
  miss_low_pick #(.N(N_ENTRIES)) i_pick_pend (
    .req_i(pend_q), .found_o(pend_found), .idx_o(pend_idx)
  );

  // entry under replay accepts no new targets until freed
  assign hit_busy = rp_act_q && (rp_idx_q == hit_idx);
  assign hit_full = cnt_q[hit_idx] == CW'(N_TGTS);
  assign stall_o  = miss_valid_i && (hit_any ? (hit_busy || hit_full) : !free_found);
  assign acc_new  = miss_valid_i && !hit_any && free_found;
  assign acc_sec  = miss_valid_i && hit_any && !hit_busy && !hit_full;
  assign rp_last  = rp_act_q && ((CW'(rp_slot_q) + CW'(1)) == cnt_q[rp_idx_q]);
  assign rsp_fire = fill_rsp_valid_i && !rp_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      pend_q <= '0;
      line_q <= '0;
      for (int e = 0; e < N_ENTRIES; e++) begin
        cnt_q[e] <= '0;
        for (int s = 0; s < N_TGTS; s++) tgt_q[e][s] <= '0;
      end
    end else begin
      if (acc_new) begin
        vld_q[free_idx]    <= 1'b1;
        pend_q[free_idx]   <= 1'b1;
        line_q[free_idx]   <= miss_line_i;
        tgt_q[free_idx][0] <= '{id: miss_id_i, off: miss_off_i};
        cnt_q[free_idx]    <= CW'(1);
      end
      if (acc_sec) begin
        tgt_q[hit_idx][cnt_q[hit_idx][SW-1:0]] <= '{id: miss_id_i, off: miss_off_i};
        cnt_q[hit_idx] <= cnt_q[hit_idx] + CW'(1);
      end
      if (rp_last) vld_q[rp_idx_q] <= 1'b0;
      if (!req_busy_q && pend_found) pend_q[pend_idx] <= 1'b0;
    end
  end

  // request register: a presented request is locked until taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_busy_q <= 1'b0;
      req_idx_q  <= '0;
    end else if (req_busy_q) begin
      if (fill_req_ready_i) req_busy_q <= 1'b0;
    end else if (pend_found) begin
      req_busy_q <= 1'b1;
      req_idx_q  <= pend_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_act_q  <= 1'b0;
      rp_idx_q  <= '0;
      rp_slot_q <= '0;
      rp_data_q <= '0;
    end else if (rsp_fire) begin
      rp_act_q  <= 1'b1;
      rp_idx_q  <= fill_rsp_idx_i;
      rp_slot_q <= '0;
      rp_data_q <= fill_rsp_data_i;
    end else if (rp_act_q) begin
      if (rp_last) rp_act_q <= 1'b0;
      else         rp_slot_q <= rp_slot_q + SW'(1);
    end
  end

  assign fill_req_valid_o = req_busy_q;
  assign fill_req_idx_o   = req_idx_q;
  assign fill_req_line_o  = line_q[req_idx_q];
  assign fill_rsp_ready_o = !rp_act_q;
  assign replay_valid_o   = rp_act_q;
  assign replay_id_o      = tgt_q[rp_idx_q][rp_slot_q].id;
  assign replay_off_o     = tgt_q[rp_idx_q][rp_slot_q].off;
  assign replay_data_o    = rp_data_q;

  p_full_on_primary_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i && !hit_any && stall_o |-> &vld_q);

  p_req_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_valid_o && !fill_req_ready_i |=>
      fill_req_valid_o && $stable(fill_req_idx_o) && $stable(fill_req_line_o));

  p_single_owner_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));

  p_freed_after_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rp_last |=> !vld_q[$past(rp_idx_q)]);

  p_replay_owner_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_valid_o |-> vld_q[rp_idx_q]);
endmodule

// File: tb/test_miss_track_file.sv
module test_miss_track_file;
  import miss_track_pkg::*;

  localparam int unsigned CLK_P   = 10;
  localparam int unsigned LINE_AW = 26;
  localparam int unsigned LINE_W  = 64;
  localparam int unsigned IW      = 2;
  localparam int unsigned NV      = 9;

  // {stall, id, off, line}
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 4'd1, 4'd0, 26'h100},  // A -> entry 0
    {1'b0, 4'd2, 4'd0, 26'h200},  // B -> entry 1
    {1'b0, 4'd3, 4'd5, 26'h100},  // A merged
    {1'b1, 4'd4, 4'd6, 26'h100},  // A slots full
    {1'b0, 4'd5, 4'd0, 26'h300},  // C -> entry 2
    {1'b0, 4'd6, 4'd0, 26'h400},  // D -> entry 3
    {1'b1, 4'd7, 4'd0, 26'h500},  // E, table full
    {1'b0, 4'd8, 4'd3, 26'h200},  // B merged
    {1'b1, 4'd9, 4'd1, 26'h200}   // B slots full
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic miss_valid_i = 1'b0;
  logic [LINE_AW-1:0] miss_line_i = '0;
  logic [ID_W-1:0] miss_id_i = '0;
  logic [OFF_W-1:0] miss_off_i = '0;
  logic stall_o;
  logic fill_req_valid_o;
  logic fill_req_ready_i = 1'b0;
  logic [LINE_AW-1:0] fill_req_line_o;
  logic [IW-1:0] fill_req_idx_o;
  logic fill_rsp_valid_i = 1'b0;
  logic fill_rsp_ready_o;
  logic [IW-1:0] fill_rsp_idx_i = '0;
  logic [LINE_W-1:0] fill_rsp_data_i = '0;
  logic replay_valid_o;
  logic [ID_W-1:0] replay_id_o;
  logic [OFF_W-1:0] replay_off_o;
  logic [LINE_W-1:0] replay_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P / 2) clk = ~clk;

  miss_track_file #(.N_ENTRIES(4), .N_TGTS(2), .LINE_AW(LINE_AW), .LINE_W(LINE_W)) i_miss_track_file (
    .clk_i(clk), .rst_ni(rst_ni),
    .miss_valid_i(miss_valid_i), .miss_line_i(miss_line_i),
    .miss_id_i(miss_id_i), .miss_off_i(miss_off_i), .stall_o(stall_o),
    .fill_req_valid_o(fill_req_valid_o), .fill_req_ready_i(fill_req_ready_i),
    .fill_req_line_o(fill_req_line_o), .fill_req_idx_o(fill_req_idx_o),
    .fill_rsp_valid_i(fill_rsp_valid_i), .fill_rsp_ready_o(fill_rsp_ready_o),
    .fill_rsp_idx_i(fill_rsp_idx_i), .fill_rsp_data_i(fill_rsp_data_i),
    .replay_valid_o(replay_valid_o), .replay_id_o(replay_id_o),
    .replay_off_o(replay_off_o), .replay_data_o(replay_data_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic take_req(input logic [IW-1:0] idx, input logic [LINE_AW-1:0] line, input string req);
    for (int k = 0; k < 10 && !fill_req_valid_o; k++) @(negedge clk);
    chk(fill_req_valid_o == 1'b1, req, 64'(fill_req_valid_o), 64'd1);
    chk(fill_req_idx_o == idx, req, 64'(fill_req_idx_o), 64'(idx));
    chk(fill_req_line_o == line, req, 64'(fill_req_line_o), 64'(line));
    fill_req_ready_i = 1'b1;
    @(negedge clk);
    fill_req_ready_i = 1'b0;
  endtask

  task automatic send_rsp(input logic [IW-1:0] idx, input logic [LINE_W-1:0] data);
    @(negedge clk);
    chk(fill_rsp_ready_o == 1'b1, "R9 ready idle", 64'(fill_rsp_ready_o), 64'd1);
    fill_rsp_valid_i = 1'b1;
    fill_rsp_idx_i   = idx;
    fill_rsp_data_i  = data;
    @(negedge clk);
    fill_rsp_valid_i = 1'b0;
    #1;
  endtask

  task automatic chk_replay(input logic [ID_W-1:0] id, input logic [OFF_W-1:0] off,
                            input logic [LINE_W-1:0] data, input string req);
    chk(replay_valid_o == 1'b1, req, 64'(replay_valid_o), 64'd1);
    chk(replay_id_o == id, req, 64'(replay_id_o), 64'(id));
    chk(replay_off_o == off, req, 64'(replay_off_o), 64'(off));
    chk(replay_data_o == data, req, replay_data_o, data);
  endtask

  initial begin
    #(CLK_P * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(fill_req_valid_o == 1'b0, "R1 req", 64'(fill_req_valid_o), 64'd0);
    chk(replay_valid_o == 1'b0, "R1 replay", 64'(replay_valid_o), 64'd0);
    chk(stall_o == 1'b0, "R1 stall", 64'(stall_o), 64'd0);
    chk(fill_rsp_ready_o == 1'b1, "R1 rsp ready", 64'(fill_rsp_ready_o), 64'd1);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 R4 R5 R6 table of misses, requests held back
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      miss_valid_i = 1'b1;
      miss_line_i  = VEC[i][25:0];
      miss_off_i   = VEC[i][29:26];
      miss_id_i    = VEC[i][33:30];
      #1;
      chk(stall_o == VEC[i][34], "R2/R4/R5/R6 stall", 64'(stall_o), 64'(VEC[i][34]));
    end
    @(negedge clk);
    miss_valid_i = 1'b0;
    #1;
    chk(stall_o == 1'b0, "R10 idle stall", 64'(stall_o), 64'd0);

    // R3 request held while not ready, then lowest entry first
    chk(fill_req_valid_o == 1'b1, "R3 held", 64'(fill_req_valid_o), 64'd1);
    take_req(2'd0, 26'h100, "R3 req A");
    take_req(2'd1, 26'h200, "R3 req B");
    take_req(2'd2, 26'h300, "R3 req C");
    take_req(2'd3, 26'h400, "R3 req D");
    repeat (3) @(negedge clk);
    #1;
    chk(fill_req_valid_o == 1'b0, "R4 no extra request", 64'(fill_req_valid_o), 64'd0);

    // R7 R8 R9 replay of entry 1 with a miss to the same line held across it
    send_rsp(2'd1, 64'hB0B0_0000_0000_B0B0);
    miss_valid_i = 1'b1;
    miss_line_i  = 26'h200;
    miss_id_i    = 4'd10;
    miss_off_i   = 4'd1;
    #1;
    chk_replay(4'd2, 4'd0, 64'hB0B0_0000_0000_B0B0, "R7 B first");
    chk(fill_rsp_ready_o == 1'b0, "R9 busy", 64'(fill_rsp_ready_o), 64'd0);
    chk(stall_o == 1'b1, "R8 stall during replay", 64'(stall_o), 64'd1);
    @(negedge clk);
    #1;
    chk_replay(4'd8, 4'd3, 64'hB0B0_0000_0000_B0B0, "R7 B second");
    chk(stall_o == 1'b1, "R8 stall on freeing cycle", 64'(stall_o), 64'd1);
    @(negedge clk);
    #1;
    chk(replay_valid_o == 1'b0, "R7 exact count", 64'(replay_valid_o), 64'd0);
    chk(stall_o == 1'b0, "R8 primary after free", 64'(stall_o), 64'd0);
    @(negedge clk);
    miss_valid_i = 1'b0;
    take_req(2'd1, 26'h200, "R8 new request");

    // R6 table full again
    @(negedge clk);
    miss_valid_i = 1'b1;
    miss_line_i  = 26'h600;
    miss_id_i    = 4'd11;
    miss_off_i   = 4'd2;
    #1;
    chk(stall_o == 1'b1, "R6 full", 64'(stall_o), 64'd1);
    @(negedge clk);
    miss_valid_i = 1'b0;

    // R7 R5 entry 0: two targets in order, stalled third absent
    send_rsp(2'd0, 64'h0A0A_1111_2222_0A0A);
    chk_replay(4'd1, 4'd0, 64'h0A0A_1111_2222_0A0A, "R7 A first");
    @(negedge clk);
    #1;
    chk_replay(4'd3, 4'd5, 64'h0A0A_1111_2222_0A0A, "R7 A second");
    @(negedge clk);
    #1;
    chk(replay_valid_o == 1'b0, "R5 no stalled target", 64'(replay_valid_o), 64'd0);

    // R7 single target entry 2
    send_rsp(2'd2, 64'h0C0C_3333_4444_0C0C);
    chk_replay(4'd5, 4'd0, 64'h0C0C_3333_4444_0C0C, "R7 C only");
    @(negedge clk);
    #1;
    chk(replay_valid_o == 1'b0, "R7 C count", 64'(replay_valid_o), 64'd0);

    // R2 lowest free entry (0 and 2 free) takes the new line
    @(negedge clk);
    miss_valid_i = 1'b1;
    miss_line_i  = 26'h600;
    miss_id_i    = 4'd11;
    miss_off_i   = 4'd2;
    #1;
    chk(stall_o == 1'b0, "R2 accept", 64'(stall_o), 64'd0);
    @(negedge clk);
    miss_valid_i = 1'b0;
    take_req(2'd0, 26'h600, "R2 lowest free");

    summary();
  end
endmodule